// File: doc/BRIEF.md
# HDLC Receive Deframer with Packet FIFO

This block turns a serial HDLC line into a byte stream that a host can read. One bit is taken on each clock where the bit-rate enable is high. The bit is first optionally inverted, and then passed through the framing logic. That logic looks for the opening flag, strips the zeros the transmitter inserted, and packs the remaining data bits into bytes, least significant bit first. It runs a CRC-16 over every byte. A closing flag or a run of ones ends the frame. Every byte of a frame, including the two check bytes, is written into a 256-entry receive FIFO. The last entry of the frame carries an end-of-packet mark and a 2-bit completion status.

A frame's bytes become visible on the read port only once that frame has ended. If a frame turns out to be too short, the write pointer is wound back to where the frame started, so the frame leaves no trace. A watermark output rises while the FIFO holds more bytes than a threshold chosen by a 3-bit code. A sticky overflow output records that bytes were lost to a full FIFO. A soft-reset input acts on its rising edge only. It empties the FIFO, clears the overflow flag and makes the receiver wait for a new opening flag.

Top module: `hdlc_rx_deframer`

## Requirements
- R1: A soft reset acts only on a 0-to-1 change of `softRst`. On that change, `rdValid`, `hiWm` and `overflow` go low and all stored bytes are discarded. Holding `softRst` high has no further effect, and it must go low and high again for a second flush.
- R2: After a soft reset, a partly received frame is discarded, and bits are ignored until a flag is seen.
- R3: With `invEn` high, every line bit is complemented before any framing step. A frame sent fully complemented, flags included, is then received exactly as an uninverted one.
- R4: The pattern 01111110 opens and closes frames. Idle flags, and flags with no bytes between them, store nothing.
- R5: A 0 that follows five 1s inside a frame is removed and is not a data bit.
- R6: Data bits are packed least significant bit first. Every byte of a frame, including the two CRC bytes, is stored in arrival order. Only the last byte has `rdEop`=1; all other bytes read with `rdEop`=0 and `rdStat`=0.
- R7: A frame closed by a flag is tagged `rdStat`=0 when the CRC-16 register, with polynomial 0x8408 reflected, initial value 0xFFFF and run over all bytes, ends at 0xF0B8. Otherwise it is tagged `rdStat`=1.
- R8: Seven 1s in a row inside a frame abort it. If the frame holds at least one byte, its last stored byte is tagged `rdEop`=1 with `rdStat`=2, and any bits not yet packed into a byte are dropped. The receiver then hunts for a flag.
- R9: A flag-closed frame of 1 to 3 bytes is discarded, and nothing of it is ever readable.
- R10: A flag-closed frame whose data-bit count is not a multiple of 8 is tagged `rdStat`=3. Before the frame is tagged, the flag's own leading bits complete the partial byte, and that byte is stored.
- R11: `hiWm` is high exactly while the number of stored bytes exceeds 16 + 32·`wmSel`.
- R12: A byte that arrives while 256 bytes are stored is dropped, and `overflow` goes high and stays high until a soft reset. The end-of-packet tag lands on the frame's last stored byte.
- R13: `rdValid` is high while at least one byte of a finished frame is unread. A cycle with `rdEn` and `rdValid` both high removes the head entry. Bytes of a frame still being received cannot be read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| bitEn | input | 1 | Qualifies `rxBit` for this clock |
| rxBit | input | 1 | Serial line bit |
| invEn | input | 1 | Complement every line bit |
| softRst | input | 1 | Flush and re-hunt on rising edge |
| wmSel | input | 3 | Watermark code, threshold 16 + 32·code |
| rdEn | input | 1 | Pop the head entry |
| rdValid | output | 1 | Head entry is readable |
| rdData | output | 8 | Head byte |
| rdEop | output | 1 | Head byte ends a frame |
| rdStat | output | 2 | Frame status on the end byte: 0 good, 1 CRC error, 2 abort, 3 misaligned |
| hiWm | output | 1 | Fill level above the watermark |
| overflow | output | 1 | Sticky lost-byte flag |

## Verification
The bench keeps the default 8-bit FIFO address, so the FIFO has the full 256 entries. This lets it cross the top watermark code (240) one byte at a time by reading, and then fill the FIFO until a frame is cut short by overflow. The minimum frame length stays at 4, so frames of 1 to 3 bytes exercise the rewind of the write pointer. Random frames of random length and random CRC, sent with random gaps in the bit enable and with inversion switched between frames, are mixed with directed frames. The directed frames cover stuffing-heavy bytes, aborts, misalignment and soft resets in the middle of a frame.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;

  typedef enum logic [1:0] {
    STAT_GOOD  = 2'd0,
    STAT_CRC   = 2'd1,
    STAT_ABORT = 2'd2,
    STAT_ALIGN = 2'd3
  } frameStat_e;

  // Strobes from the framing control to the FIFO datapath.
  typedef struct packed {
    logic       flush;
    logic       push;
    logic [7:0] data;
    logic       commit;
    logic       rollback;
    frameStat_e stat;
  } rxStrobe_t;

  localparam logic [15:0] CRC_INIT = 16'hFFFF;
  localparam logic [15:0] CRC_GOOD = 16'hF0B8;
  localparam logic [15:0] CRC_POLY = 16'h8408;

  function automatic logic [15:0] crcStep(input logic [15:0] crcIn, input logic [7:0] dIn);
    logic [15:0] c;
    c = crcIn;
    for (int i = 0; i < 8; i++) begin
      if (c[0] ^ dIn[i]) c = (c >> 1) ^ CRC_POLY;
      else               c = c >> 1;
    end
    return c;
  endfunction

endpackage

// File: rtl/hdlc_rx_ctrl.sv
module hdlc_rx_ctrl
  import hdlc_rx_pkg::*;
#(
  parameter int MIN_FRAME = 4
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      bitEn,
  input  logic      rxBit,
  input  logic      invEn,
  input  logic      softRst,
  output rxStrobe_t strobe
);

  localparam int CNT_W = $clog2(MIN_FRAME + 1);
  localparam logic [CNT_W-1:0] MIN_CNT = CNT_W'(MIN_FRAME);

  logic             rstPrev;
  logic             flushEdge;
  logic             lineBit;
  logic [2:0]       onesRun;
  logic [2:0]       nextOnes;
  logic             inFrame;
  logic [2:0]       bitCnt;
  logic [7:0]       byteSr;
  logic [7:0]       newByte;
  logic [CNT_W-1:0] byteCnt;
  logic [15:0]      crcReg;
  logic             flagSeen;
  logic             abortSeen;
  logic             dataBit;
  frameStat_e       closeStat;

  assign flushEdge = softRst & ~rstPrev;
  assign lineBit   = rxBit ^ invEn;
  assign newByte   = {lineBit, byteSr[7:1]};
  assign flagSeen  = ~lineBit & (onesRun == 3'd6);
  assign abortSeen = lineBit & (onesRun == 3'd6);
  assign dataBit   = (onesRun < 3'd5);

  always_comb begin
    if (!lineBit)              nextOnes = 3'd0;
    else if (onesRun == 3'd7)  nextOnes = 3'd7;
    else                       nextOnes = onesRun + 3'd1;
  end

  always_comb begin
    if (bitCnt != 3'd6)          closeStat = STAT_ALIGN;
    else if (crcReg != CRC_GOOD) closeStat = STAT_CRC;
    else                         closeStat = STAT_GOOD;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rstPrev <= 1'b0;
      onesRun <= 3'd0;
      inFrame <= 1'b0;
      bitCnt  <= 3'd0;
      byteSr  <= 8'd0;
      byteCnt <= '0;
      crcReg  <= CRC_INIT;
      strobe  <= '0;
    end else begin
      rstPrev <= softRst;
      strobe  <= '0;
      if (flushEdge) begin
        strobe.flush <= 1'b1;
        onesRun      <= 3'd0;
        inFrame      <= 1'b0;
        bitCnt       <= 3'd0;
        byteCnt      <= '0;
        crcReg       <= CRC_INIT;
      end else if (bitEn) begin
        onesRun <= nextOnes;
        if (flagSeen) begin
          inFrame <= 1'b1;
          bitCnt  <= 3'd0;
          byteCnt <= '0;
          crcReg  <= CRC_INIT;
          if (inFrame && byteCnt != '0) begin
            if (byteCnt < MIN_CNT) begin
              strobe.rollback <= 1'b1;
            end else begin
              strobe.commit <= 1'b1;
              strobe.stat   <= closeStat;
            end
          end
        end else if (abortSeen) begin
          inFrame <= 1'b0;
          if (inFrame && byteCnt != '0) begin
            strobe.commit <= 1'b1;
            strobe.stat   <= STAT_ABORT;
          end
        end else if (dataBit && inFrame) begin
          byteSr <= newByte;
          bitCnt <= bitCnt + 3'd1;
          if (bitCnt == 3'd7) begin
            strobe.push <= 1'b1;
            strobe.data <= newByte;
            crcReg      <= crcStep(crcReg, newByte);
            if (byteCnt != MIN_CNT) byteCnt <= byteCnt + 1'b1;
          end
        end
      end
    end
  end

  // R1: a flush strobe always coincides with a restarted hunt
  a_r1_flush_restarts_hunt: assert property (@(posedge clk) disable iff (!rstN)
    strobe.flush |-> (!inFrame && bitCnt == 3'd0 && byteCnt == '0));

  // R6: a byte leaves only on a byte boundary
  a_r6_push_on_boundary: assert property (@(posedge clk) disable iff (!rstN)
    strobe.push |-> (bitCnt == 3'd0));

  // R5: a stuffed zero neither advances the bit count nor yields a byte
  a_r5_stuffed_dropped: assert property (@(posedge clk) disable iff (!rstN)
    (bitEn && inFrame && !flushEdge && !lineBit && onesRun == 3'd5)
      |=> ($stable(bitCnt) && !strobe.push));

endmodule

// File: rtl/hdlc_rx_fifo.sv
module hdlc_rx_fifo
  import hdlc_rx_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int SEL_W   = 3,
  parameter int WM_BASE = 16,
  parameter int WM_STEP = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  rxStrobe_t        strobe,
  input  logic             rdEn,
  input  logic [SEL_W-1:0] wmSel,
  output logic             rdValid,
  output logic [7:0]       rdData,
  output logic             rdEop,
  output logic [1:0]       rdStat,
  output logic             hiWm,
  output logic             overflow
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam int PW    = ADDR_W + 1;
  localparam logic [PW-1:0] FULL_CNT = PW'(DEPTH);

  logic [7:0]        memData [DEPTH];
  logic              memEop  [DEPTH];
  logic [1:0]        memStat [DEPTH];
  logic [PW-1:0]     wrPtr, frmPtr, rdPtr;
  logic [PW-1:0]     occ, visible;
  logic [ADDR_W-1:0] lastIdx;
  logic              full, pop, wrOk, tagOk;
  int                thr;

  assign occ     = wrPtr - rdPtr;
  assign visible = frmPtr - rdPtr;
  assign full    = (occ == FULL_CNT);
  assign rdValid = (visible != '0);
  assign pop     = rdEn & rdValid;
  assign wrOk    = strobe.push & ~full & ~strobe.flush;
  assign tagOk   = strobe.commit & (wrPtr != frmPtr) & ~strobe.flush;
  assign lastIdx = wrPtr[ADDR_W-1:0] - 1'b1;

  assign rdData  = memData[rdPtr[ADDR_W-1:0]];
  assign rdEop   = memEop[rdPtr[ADDR_W-1:0]];
  assign rdStat  = memStat[rdPtr[ADDR_W-1:0]];

  always_comb begin
    thr  = WM_BASE + WM_STEP * int'(wmSel);
    hiWm = int'(occ) > thr;
  end

  always_ff @(posedge clk) begin
    if (wrOk) begin
      memData[wrPtr[ADDR_W-1:0]] <= strobe.data;
      memEop[wrPtr[ADDR_W-1:0]]  <= 1'b0;
      memStat[wrPtr[ADDR_W-1:0]] <= 2'd0;
    end
    if (tagOk) begin
      memEop[lastIdx]  <= 1'b1;
      memStat[lastIdx] <= strobe.stat;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr    <= '0;
      frmPtr   <= '0;
      rdPtr    <= '0;
      overflow <= 1'b0;
    end else if (strobe.flush) begin
      wrPtr    <= '0;
      frmPtr   <= '0;
      rdPtr    <= '0;
      overflow <= 1'b0;
    end else begin
      if (pop) rdPtr <= rdPtr + 1'b1;
      if (strobe.push) begin
        if (full) overflow <= 1'b1;
        else      wrPtr    <= wrPtr + 1'b1;
      end
      if (strobe.commit)   frmPtr <= wrPtr;
      if (strobe.rollback) wrPtr  <= frmPtr;
    end
  end

  // R12: fill level never exceeds the FIFO depth
  a_r12_occ_bounded: assert property (@(posedge clk) disable iff (!rstN)
    occ <= FULL_CNT);

  // R12: overflow stays set until a flush
  a_r12_ovf_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (overflow && !strobe.flush) |=> overflow);

  // R13: readable entries are a subset of stored entries
  a_r13_visible_within_occ: assert property (@(posedge clk) disable iff (!rstN)
    visible <= occ);

  // R1: a flush leaves an empty FIFO with overflow cleared
  a_r1_flush_empties: assert property (@(posedge clk) disable iff (!rstN)
    strobe.flush |=> (occ == '0 && !overflow && !rdValid));

  // R11: watermark never high at or below the smallest threshold
  a_r11_wm_above_base: assert property (@(posedge clk) disable iff (!rstN)
    hiWm |-> (int'(occ) > WM_BASE));

endmodule

// File: rtl/hdlc_rx_deframer.sv
module hdlc_rx_deframer
  import hdlc_rx_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int SEL_W     = 3,
  parameter int WM_BASE   = 16,
  parameter int WM_STEP   = 32,
  parameter int MIN_FRAME = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             bitEn,
  input  logic             rxBit,
  input  logic             invEn,
  input  logic             softRst,
  input  logic [SEL_W-1:0] wmSel,
  input  logic             rdEn,
  output logic             rdValid,
  output logic [7:0]       rdData,
  output logic             rdEop,
  output logic [1:0]       rdStat,
  output logic             hiWm,
  output logic             overflow
);

  rxStrobe_t strobe;

  hdlc_rx_ctrl #(.MIN_FRAME(MIN_FRAME)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .bitEn   (bitEn),
    .rxBit   (rxBit),
    .invEn   (invEn),
    .softRst (softRst),
    .strobe  (strobe)
  );

  hdlc_rx_fifo #(
    .ADDR_W  (ADDR_W),
    .SEL_W   (SEL_W),
    .WM_BASE (WM_BASE),
    .WM_STEP (WM_STEP)
  ) u_fifo (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .rdEn     (rdEn),
    .wmSel    (wmSel),
    .rdValid  (rdValid),
    .rdData   (rdData),
    .rdEop    (rdEop),
    .rdStat   (rdStat),
    .hiWm     (hiWm),
    .overflow (overflow)
  );

endmodule

// File: tb/sim_hdlc_rx_deframer.sv
module sim_hdlc_rx_deframer;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       bitEn = 1'b0;
  logic       rxBit = 1'b0;
  logic       invEn = 1'b0;
  logic       softRst = 1'b0;
  logic [2:0] wmSel = 3'd0;
  logic       rdEn = 1'b0;
  logic       rdValid, rdEop, hiWm, overflow;
  logic [7:0] rdData;
  logic [1:0] rdStat;

  int nChecks = 0;
  int nFails  = 0;
  int txOnes  = 0;
  int fbLen   = 0;
  logic [7:0]  fb [0:299];
  logic [10:0] expQ [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  hdlc_rx_deframer u0 (
    .clk(clk), .rstN(rstN), .bitEn(bitEn), .rxBit(rxBit), .invEn(invEn),
    .softRst(softRst), .wmSel(wmSel), .rdEn(rdEn), .rdValid(rdValid),
    .rdData(rdData), .rdEop(rdEop), .rdStat(rdStat), .hiWm(hiWm),
    .overflow(overflow)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] crcUpd(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c;
    for (int i = 0; i < 8; i++) r = (r[0] ^ d[i]) ? ((r >> 1) ^ 16'h8408) : (r >> 1);
    return r;
  endfunction

  function automatic int wmThr(input logic [2:0] s);
    return 16 + 32 * int'(s);
  endfunction

  task automatic driveBit(input bit b);
    @(negedge clk);
    rxBit = b ^ invEn;
    bitEn = 1'b1;
    @(negedge clk);
    bitEn = 1'b0;
    if ($urandom_range(0, 1) == 1) @(negedge clk);
  endtask

  task automatic sendStuffed(input bit b);
    driveBit(b);
    if (b) begin
      txOnes++;
      if (txOnes == 5) begin
        driveBit(1'b0);
        txOnes = 0;
      end
    end else txOnes = 0;
  endtask

  task automatic sendByte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) sendStuffed(v[i]);
  endtask

  task automatic sendFlag();
    driveBit(1'b0);
    for (int i = 0; i < 6; i++) driveBit(1'b1);
    driveBit(1'b0);
    txOnes = 0;
  endtask

  task automatic sendAbort();
    for (int i = 0; i < 7; i++) driveBit(1'b1);
    txOnes = 0;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  // n total bytes; n >= 3 gets a trailing FCS, bad flips one FCS bit
  task automatic buildFrame(input int n, input bit bad);
    logic [15:0] c;
    fbLen = n;
    for (int i = 0; i < n; i++) fb[i] = 8'($urandom);
    if (n >= 3) begin
      c = 16'hFFFF;
      for (int i = 0; i < n - 2; i++) c = crcUpd(c, fb[i]);
      c = ~c;
      fb[n-2] = c[7:0];
      fb[n-1] = c[15:8] ^ (bad ? 8'h10 : 8'h00);
    end
  endtask

  task automatic sendBody(input int nSend);
    for (int i = 0; i < nSend; i++) sendByte(fb[i]);
  endtask

  task automatic expectBytes(input int nStore, input logic [1:0] st);
    for (int i = 0; i < nStore; i++)
      expQ.push_back({(i == nStore - 1), (i == nStore - 1) ? st : 2'd0, fb[i]});
  endtask

  task automatic readCheck(input string req);
    logic [10:0] e;
    @(negedge clk);
    e = expQ.pop_front();
    chk(rdValid == 1'b1, req, "rdValid", int'(rdValid), 1);
    chk({rdEop, rdStat, rdData} == e, req, "entry {eop,stat,data}",
        int'({rdEop, rdStat, rdData}), int'(e));
    rdEn = rdValid;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic drainCheck(input string req);
    while (expQ.size() > 0) readCheck(req);
    @(negedge clk);
    chk(rdValid == 1'b0, req, "rdValid after drain", int'(rdValid), 0);
  endtask

  task automatic pulseSoftRst();
    @(negedge clk);
    softRst = 1'b1;
    expQ.delete();
    @(negedge clk);
    softRst = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog expired actual=0x0 expected=0x1");
    $display("[TB] %0d tests run, %0d failed", nChecks + 1, nFails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0041));
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(rdValid == 1'b0, "R1", "reset rdValid", int'(rdValid), 0);
    chk(hiWm == 1'b0, "R1", "reset hiWm", int'(hiWm), 0);
    chk(overflow == 1'b0, "R1", "reset overflow", int'(overflow), 0);

    // R4: idle flags store nothing
    repeat (4) sendFlag();
    settle();
    chk(rdValid == 1'b0, "R4", "idle flags rdValid", int'(rdValid), 0);

    // R6 R7 R13: good frame, invisible until closed
    buildFrame(10, 1'b0);
    sendFlag(); sendBody(10);
    settle();
    chk(rdValid == 1'b0, "R13", "mid-frame rdValid", int'(rdValid), 0);
    sendFlag(); sendFlag(); settle();
    expectBytes(10, 2'd0);
    drainCheck("R6");

    // R5: stuffing-heavy payload
    fb[0] = 8'hFF; fb[1] = 8'h7E; fb[2] = 8'h3F; fb[3] = 8'hFC; fb[4] = 8'hF8;
    begin
      logic [15:0] c;
      c = 16'hFFFF;
      for (int i = 0; i < 5; i++) c = crcUpd(c, fb[i]);
      c = ~c; fb[5] = c[7:0]; fb[6] = c[15:8];
    end
    sendFlag(); sendBody(7); sendFlag(); settle();
    expectBytes(7, 2'd0);
    drainCheck("R5");

    // R7: CRC error
    buildFrame(8, 1'b1);
    sendFlag(); sendBody(8); sendFlag(); settle();
    expectBytes(8, 2'd1);
    drainCheck("R7");

    // R9: short frames
    buildFrame(3, 1'b0);
    sendFlag(); sendBody(3); sendFlag();
    buildFrame(1, 1'b0);
    sendBody(1); sendFlag(); sendFlag(); settle();
    chk(rdValid == 1'b0, "R9", "short frames rdValid", int'(rdValid), 0);

    // R8: abort after 6 bytes plus partial bits
    buildFrame(8, 1'b0);
    sendFlag(); sendBody(6); sendStuffed(1'b0); sendStuffed(1'b1);
    sendAbort(); sendFlag(); sendFlag(); settle();
    expectBytes(6, 2'd2);
    drainCheck("R8");

    // R10: three extra zero bits; flag bits complete byte 0xF0
    buildFrame(6, 1'b0);
    fb[4] = 8'h00;
    sendFlag(); sendBody(5);
    for (int i = 0; i < 3; i++) sendStuffed(1'b0);
    sendFlag(); sendFlag(); settle();
    fb[5] = 8'hF0;
    expectBytes(6, 2'd3);
    drainCheck("R10");

    // R3: inverted line
    invEn = 1'b1;
    buildFrame(12, 1'b0);
    sendFlag(); sendBody(12); sendFlag(); settle();
    expectBytes(12, 2'd0);
    drainCheck("R3");
    invEn = 1'b0;

    // R1: flush, then held high has no further effect
    buildFrame(20, 1'b0);
    sendFlag(); sendBody(20); sendFlag(); settle();
    chk(hiWm == 1'b1, "R11", "20 bytes sel0 hiWm", int'(hiWm), 1);
    @(negedge clk); softRst = 1'b1; expQ.delete();
    settle();
    chk(rdValid == 1'b0, "R1", "flush rdValid", int'(rdValid), 0);
    chk(hiWm == 1'b0, "R1", "flush hiWm", int'(hiWm), 0);
    buildFrame(6, 1'b0);
    sendFlag(); sendBody(6); sendFlag(); settle();
    chk(rdValid == 1'b1, "R1", "held softRst no reflush", int'(rdValid), 1);
    expectBytes(6, 2'd0);
    drainCheck("R1");
    @(negedge clk); softRst = 1'b0;

    // R2: soft reset mid-frame discards the partial frame
    buildFrame(10, 1'b0);
    sendFlag(); sendBody(4);
    pulseSoftRst();
    for (int i = 4; i < 10; i++) sendByte(fb[i]);
    sendFlag(); sendFlag(); settle();
    chk(rdValid == 1'b0, "R2", "partial frame after flush", int'(rdValid), 0);

    // R11: watermark boundaries at code 7
    wmSel = 3'd7;
    buildFrame(200, 1'b0);
    sendFlag(); sendBody(200); sendFlag(); settle();
    expectBytes(200, 2'd0);
    buildFrame(40, 1'b0);
    sendBody(40); sendFlag(); settle();
    expectBytes(40, 2'd0);
    chk(hiWm == 1'b0, "R11", "240 bytes sel7", int'(hiWm), 0);
    @(negedge clk); wmSel = 3'd6; @(negedge clk);
    chk(hiWm == 1'b1, "R11", "240 bytes sel6", int'(hiWm), 1);
    wmSel = 3'd7;
    buildFrame(4, 1'b0);
    sendBody(4); sendFlag(); settle();
    expectBytes(4, 2'd0);
    chk(hiWm == 1'b1, "R11", "244 bytes sel7", int'(hiWm), 1);
    for (int i = 0; i < 3; i++) readCheck("R13");
    @(negedge clk);
    chk(hiWm == 1'b1, "R11", "241 bytes sel7", int'(hiWm), 1);
    readCheck("R13");
    @(negedge clk);
    chk(hiWm == 1'b0, "R11", "240 bytes sel7 after read", int'(hiWm), 0);

    // R12: overflow cuts a 30-byte frame to 16 stored bytes
    buildFrame(30, 1'b0);
    sendBody(30); sendFlag(); settle();
    expectBytes(256 - expQ.size(), 2'd0);
    chk(overflow == 1'b1, "R12", "overflow set", int'(overflow), 1);
    drainCheck("R12");
    chk(overflow == 1'b1, "R12", "overflow sticky", int'(overflow), 1);
    pulseSoftRst();
    settle();
    chk(overflow == 1'b0, "R12", "overflow cleared by flush", int'(overflow), 0);

    // Random mix
    for (int f = 0; f < 40; f++) begin
      int n;
      bit bad;
      n   = ($urandom_range(0, 5) == 0) ? $urandom_range(1, 3) : $urandom_range(4, 24);
      bad = ($urandom_range(0, 3) == 0);
      invEn = 1'($urandom_range(0, 1));
      wmSel = 3'($urandom_range(0, 2));
      buildFrame(n, bad);
      sendFlag(); sendBody(n); sendFlag(); settle();
      if (n >= 4) expectBytes(n, bad ? 2'd1 : 2'd0);
      chk(hiWm == (expQ.size() > wmThr(wmSel)), "R11", "random hiWm",
          int'(hiWm), int'(expQ.size() > wmThr(wmSel)));
      if (f % 5 == 4) drainCheck("R7");
    end
    drainCheck("R6");

    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule